// File: doc/BRIEF.md
# Processor control state machine

This block is the sequencer of a small 8-bit processor core. It takes a start request from the surrounding system and loads a two-byte instruction into the instruction register in two steps, high byte first. It then reads the 4-bit opcode and the addressing-mode bit that the datapath presents, and walks through a short chain of execute states. Each state raises the one-cycle strobes that the datapath acts on: an ALU result latch, register-file read and write enables, and selects for storing the low or high half of a result. A busy output is low only while the machine waits for work.

The ALU, the register file, the program counter and any memory sit outside this block. Those parts hold the opcode and mode inputs steady from the second fetch cycle until the instruction ends. Every output is decoded from the current state, and for two states also from the opcode, so a strobe is valid in the same cycle as the state that owns it.

States: `ST_RESET`, `ST_IDLE`, `ST_FETCH_HI`, `ST_FETCH_LO`, `ST_ALU_REG`, `ST_ALU_IMM`, `ST_REG_READ`, `ST_REG_WRITE`, `ST_REG_WRITE_HI`, `ST_IMM_WRITE`. The transitions are:

- Reset moves to Idle.
- Idle moves to Fetch-hi on start and otherwise holds.
- Fetch-hi moves to Fetch-lo.
- Fetch-lo goes to Idle for HALT or END and back to Fetch-hi for NOP. For any other opcode it goes to ALU-reg when the mode bit is 0 and to ALU-imm when it is 1.
- ALU-reg goes to Reg-read for COMP and to Reg-write otherwise.
- ALU-imm goes to Reg-read for COMP, to Imm-write for MOV or LOAD, and to Reg-write otherwise.
- Reg-write goes to Reg-write-hi for MUL and to Fetch-hi otherwise.
- Reg-read, Reg-write-hi and Imm-write all go to Fetch-hi.

Top module: `proc_ctrl_fsm`

## Requirements
- R1: Reset is synchronous and active-high. In every cycle after a clock edge that sees reset, busy is 1, both instruction-load strobes (active-low) are 1 and all other strobes are 0. The first edge without reset moves the machine to the idle state.
- R2: In the idle state busy is 0, the instruction-load strobes are 1 and all other strobes are 0. The machine stays idle until an edge sees start=1, and that edge moves it to the first fetch cycle.
- R3: The first fetch cycle drives only the high-byte load strobe low. The next cycle drives only the low-byte load strobe low. Busy is 1 in both cycles.
- R4: With mode bit 0 (register mode), the cycle after the second fetch raises the ALU latch. The same cycle raises the register read strobe only for opcodes ADD=0000, SUB=0001, MUL=0010, AND=0011 and OR=0100.
- R5: With mode bit 1 (immediate mode), the cycle after the second fetch raises only the ALU latch.
- R6: The register-write cycle raises the register write strobe. For MOV=1101 and LOAD=1100 it also raises the read strobe. For every other opcode it also raises the low-half store select.
- R7: For MUL, in either mode, the register-write cycle is followed by one cycle that raises both the write strobe and the high-half store select, and the machine then returns to the first fetch cycle.
- R8: In immediate mode, MOV and LOAD go from the ALU cycle to a cycle that raises only the write strobe, and then to the first fetch cycle.
- R9: COMP=1001, in either mode, goes from the ALU cycle to a cycle that raises only the read strobe. It writes nothing and then goes to the first fetch cycle.
- R10: HALT=1110 and END=1011 send the machine from the second fetch cycle straight to idle, where busy is 0.
- R11: NOP=1111 sends the machine from the second fetch cycle straight back to the first fetch cycle, with no ALU or register strobe.
- R12: Busy is 1 in every state except idle. The start input has no effect outside the idle state.
- R13: The two instruction-load strobes are never low together. The low and high store selects are never high together. The write strobe and the ALU latch are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active-high |
| start | input | 1 | Request to begin fetching; sampled only in idle |
| opcode | input | 4 | Opcode field from the instruction register |
| imm_mode | input | 1 | Addressing mode: 0 register, 1 immediate |
| busy | output | 1 | 0 only in the idle state |
| ir_hi_load_n | output | 1 | Load high instruction byte, active-low |
| ir_lo_load_n | output | 1 | Load low instruction byte, active-low |
| alu_latch | output | 1 | Capture the ALU result |
| gpr_rd | output | 1 | Register-file read enable |
| gpr_wr | output | 1 | Register-file write enable |
| store_lo | output | 1 | Write the low half of the result |
| store_hi | output | 1 | Write the high half of the result |

## Verification
Two pairs of functions share a cycle. In the register-write cycle of MOV or LOAD, the register read strobe and the write strobe are both high, and the low-half store select must stay low. In the ALU cycle of a register-mode two-operand operation, the operand read and the ALU latch are both high. The bench drives these instructions in both modes and compares the full strobe word in each cycle, so a strobe that is missing or extra in that shared cycle shows up as a wrong word. It also holds start high through the execute cycles, to show that a request arriving in the same cycle as an execute strobe leaves the sequence unchanged.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    // Width of the opcode field the sequencer decodes
    localparam int OP_W = 4;

    // Opcode encodings decoded by the sequencer
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0000;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0001;
    localparam logic [OP_W-1:0] OP_MUL  = 4'b0010;
    localparam logic [OP_W-1:0] OP_AND  = 4'b0011;
    localparam logic [OP_W-1:0] OP_OR   = 4'b0100;
    localparam logic [OP_W-1:0] OP_COMP = 4'b1001;
    localparam logic [OP_W-1:0] OP_END  = 4'b1011;
    localparam logic [OP_W-1:0] OP_LOAD = 4'b1100;
    localparam logic [OP_W-1:0] OP_MOV  = 4'b1101;
    localparam logic [OP_W-1:0] OP_HALT = 4'b1110;
    localparam logic [OP_W-1:0] OP_NOP  = 4'b1111;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_ALU_REG,
        ST_ALU_IMM,
        ST_REG_READ,
        ST_REG_WRITE,
        ST_REG_WRITE_HI,
        ST_IMM_WRITE
    } state_t;

    // Strobe bundle driven from the current state
    typedef struct packed {
        logic busy;
        logic ir_hi_load_n;
        logic ir_lo_load_n;
        logic alu_latch;
        logic gpr_rd;
        logic gpr_wr;
        logic store_lo;
        logic store_hi;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{busy: 1'b1, ir_hi_load_n: 1'b1,
                                         ir_lo_load_n: 1'b1, alu_latch: 1'b0,
                                         gpr_rd: 1'b0, gpr_wr: 1'b0,
                                         store_lo: 1'b0, store_hi: 1'b0};

endpackage

// File: rtl/ctrl_op_decode.sv
module ctrl_op_decode
    import ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output logic            is_two_src,
    output logic            is_copy,
    output logic            is_mul,
    output logic            is_cmp,
    output logic            is_stop,
    output logic            is_skip
);

    always_comb begin
        // Operations that fetch a second register operand
        is_two_src = (opcode == OP_ADD) || (opcode == OP_SUB) ||
                     (opcode == OP_MUL) || (opcode == OP_AND) ||
                     (opcode == OP_OR);
        // Data moves: the write takes a register value, not the ALU output
        is_copy    = (opcode == OP_MOV) || (opcode == OP_LOAD);
        // Double-width result needs a second write
        is_mul     = (opcode == OP_MUL);
        // Compare only reads, never writes back
        is_cmp     = (opcode == OP_COMP);
        // Instructions that stop the fetch loop
        is_stop    = (opcode == OP_HALT) || (opcode == OP_END);
        // Instruction with no execute phase
        is_skip    = (opcode == OP_NOP);
    end

endmodule

// File: rtl/ctrl_next_state.sv
module ctrl_next_state
    import ctrl_pkg::*;
(
    input  state_t state,
    input  logic   start,
    input  logic   imm_mode,
    input  logic   is_copy,
    input  logic   is_mul,
    input  logic   is_cmp,
    input  logic   is_stop,
    input  logic   is_skip,
    output state_t state_nxt
);

    always_comb begin
        state_nxt = ST_RESET;
        unique case (state)
            ST_RESET:    state_nxt = ST_IDLE;
            ST_IDLE:     state_nxt = start ? ST_FETCH_HI : ST_IDLE;
            ST_FETCH_HI: state_nxt = ST_FETCH_LO;
            ST_FETCH_LO: begin
                if (is_stop)
                    state_nxt = ST_IDLE;
                else if (is_skip)
                    state_nxt = ST_FETCH_HI;
                else if (imm_mode)
                    state_nxt = ST_ALU_IMM;
                else
                    state_nxt = ST_ALU_REG;
            end
            ST_ALU_REG:  state_nxt = is_cmp ? ST_REG_READ : ST_REG_WRITE;
            ST_ALU_IMM: begin
                if (is_cmp)
                    state_nxt = ST_REG_READ;
                else if (is_copy)
                    state_nxt = ST_IMM_WRITE;
                else
                    state_nxt = ST_REG_WRITE;
            end
            ST_REG_WRITE:    state_nxt = is_mul ? ST_REG_WRITE_HI : ST_FETCH_HI;
            ST_REG_WRITE_HI: state_nxt = ST_FETCH_HI;
            ST_REG_READ:     state_nxt = ST_FETCH_HI;
            ST_IMM_WRITE:    state_nxt = ST_FETCH_HI;
            default:         state_nxt = ST_RESET;
        endcase
    end

endmodule

// File: rtl/ctrl_strobe_gen.sv
module ctrl_strobe_gen
    import ctrl_pkg::*;
(
    input  state_t  state,
    input  logic    is_two_src,
    input  logic    is_copy,
    output strobe_t strobe
);

    always_comb begin
        strobe = STROBE_QUIET;
        unique case (state)
            ST_RESET: ;
            ST_IDLE:         strobe.busy = 1'b0;
            ST_FETCH_HI:     strobe.ir_hi_load_n = 1'b0;
            ST_FETCH_LO:     strobe.ir_lo_load_n = 1'b0;
            ST_ALU_REG: begin
                strobe.alu_latch = 1'b1;
                strobe.gpr_rd    = is_two_src;
            end
            ST_ALU_IMM:      strobe.alu_latch = 1'b1;
            ST_REG_READ:     strobe.gpr_rd = 1'b1;
            ST_REG_WRITE: begin
                strobe.gpr_wr   = 1'b1;
                strobe.gpr_rd   = is_copy;
                strobe.store_lo = !is_copy;
            end
            ST_REG_WRITE_HI: begin
                strobe.gpr_wr   = 1'b1;
                strobe.store_hi = 1'b1;
            end
            ST_IMM_WRITE:    strobe.gpr_wr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/proc_ctrl_fsm.sv
module proc_ctrl_fsm
    import ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] opcode,
    input  logic            imm_mode,
    output logic            busy,
    output logic            ir_hi_load_n,
    output logic            ir_lo_load_n,
    output logic            alu_latch,
    output logic            gpr_rd,
    output logic            gpr_wr,
    output logic            store_lo,
    output logic            store_hi
);

    state_t  state;
    state_t  state_nxt;
    strobe_t strobe;

    logic is_two_src;
    logic is_copy;
    logic is_mul;
    logic is_cmp;
    logic is_stop;
    logic is_skip;

    ctrl_op_decode u_decode (
        .opcode     (opcode),
        .is_two_src (is_two_src),
        .is_copy    (is_copy),
        .is_mul     (is_mul),
        .is_cmp     (is_cmp),
        .is_stop    (is_stop),
        .is_skip    (is_skip)
    );

    ctrl_next_state u_next (
        .state     (state),
        .start     (start),
        .imm_mode  (imm_mode),
        .is_copy   (is_copy),
        .is_mul    (is_mul),
        .is_cmp    (is_cmp),
        .is_stop   (is_stop),
        .is_skip   (is_skip),
        .state_nxt (state_nxt)
    );

    // State register: the one process that holds the machine
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_RESET;
        else
            state <= state_nxt;
    end

    ctrl_strobe_gen u_strobe (
        .state      (state),
        .is_two_src (is_two_src),
        .is_copy    (is_copy),
        .strobe     (strobe)
    );

    assign busy         = strobe.busy;
    assign ir_hi_load_n = strobe.ir_hi_load_n;
    assign ir_lo_load_n = strobe.ir_lo_load_n;
    assign alu_latch    = strobe.alu_latch;
    assign gpr_rd       = strobe.gpr_rd;
    assign gpr_wr       = strobe.gpr_wr;
    assign store_lo     = strobe.store_lo;
    assign store_hi     = strobe.store_hi;

endmodule

// File: rtl/proc_ctrl_fsm_chk.sv
module proc_ctrl_fsm_chk
    import ctrl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [OP_W-1:0] opcode,
    input logic            busy,
    input logic            ir_hi_load_n,
    input logic            ir_lo_load_n,
    input logic            alu_latch,
    input logic            gpr_rd,
    input logic            gpr_wr,
    input logic            store_lo,
    input logic            store_hi
);

    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: after an edge that saw reset, the machine sits busy with all strobes quiet
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_quiet: assert (busy && ir_hi_load_n && ir_lo_load_n &&
                                      !alu_latch && !gpr_rd && !gpr_wr &&
                                      !store_lo && !store_hi)
                else $error("R1 strobes active in reset state");
        end
    end

    // R2: idle without start stays idle
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    // R2: idle with start enters the high-byte fetch
    a_r2_idle_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> !ir_hi_load_n);

    // R3: the high-byte load is always followed by the low-byte load
    a_r3_fetch_order: assert property (@(posedge clk) disable iff (rst)
        !ir_hi_load_n |=> (!ir_lo_load_n && ir_hi_load_n));

    // R7: a high-half store comes right after a low-half store
    a_r7_high_after_low: assert property (@(posedge clk) disable iff (rst)
        store_hi |-> $past(store_lo));

    // R10: a stop opcode in the second fetch cycle leads to idle
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (rst)
        (!ir_lo_load_n && (opcode == OP_HALT || opcode == OP_END)) |=> !busy);

    // R11: the no-op refetches at once
    a_r11_nop_refetch: assert property (@(posedge clk) disable iff (rst)
        (!ir_lo_load_n && opcode == OP_NOP) |=> !ir_hi_load_n);

    // R12: any active strobe implies busy
    a_r12_busy_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (alu_latch || gpr_rd || gpr_wr || !ir_hi_load_n || !ir_lo_load_n) |-> busy);

    // R13: mutually exclusive strobes
    a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
        (ir_hi_load_n || ir_lo_load_n) && !(store_lo && store_hi) &&
        !(gpr_wr && alu_latch));

endmodule

bind proc_ctrl_fsm proc_ctrl_fsm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .opcode       (opcode),
    .busy         (busy),
    .ir_hi_load_n (ir_hi_load_n),
    .ir_lo_load_n (ir_lo_load_n),
    .alu_latch    (alu_latch),
    .gpr_rd       (gpr_rd),
    .gpr_wr       (gpr_wr),
    .store_lo     (store_lo),
    .store_hi     (store_hi)
);

// File: tb/test_proc_ctrl_fsm.sv
module test_proc_ctrl_fsm;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // Strobe word: {busy, ir_hi_n, ir_lo_n, alu_latch, gpr_rd, gpr_wr, store_lo, store_hi}
    localparam logic [7:0] W_RST  = 8'b1110_0000;
    localparam logic [7:0] W_IDLE = 8'b0110_0000;
    localparam logic [7:0] W_F1   = 8'b1010_0000;
    localparam logic [7:0] W_F2   = 8'b1100_0000;
    localparam logic [7:0] W_ARD  = 8'b1111_1000;
    localparam logic [7:0] W_ALU  = 8'b1111_0000;
    localparam logic [7:0] W_WLO  = 8'b1110_0110;
    localparam logic [7:0] W_WRD  = 8'b1110_1100;
    localparam logic [7:0] W_WHI  = 8'b1110_0101;
    localparam logic [7:0] W_IMW  = 8'b1110_0100;
    localparam logic [7:0] W_RD   = 8'b1110_1000;

    // Vector: {opcode[3:0], mode, n[2:0], word0..word3}; n words follow the second fetch
    localparam int NVEC = 16;
    localparam logic [39:0] VEC [NVEC] = '{
        {4'b0000, 1'b0, 3'd3, W_ARD, W_WLO, W_F1,  8'h00},  // ADD reg
        {4'b0001, 1'b1, 3'd3, W_ALU, W_WLO, W_F1,  8'h00},  // SUB imm
        {4'b0010, 1'b0, 3'd4, W_ARD, W_WLO, W_WHI, W_F1 },  // MUL reg
        {4'b0010, 1'b1, 3'd4, W_ALU, W_WLO, W_WHI, W_F1 },  // MUL imm
        {4'b1101, 1'b0, 3'd3, W_ALU, W_WRD, W_F1,  8'h00},  // MOV reg
        {4'b1100, 1'b0, 3'd3, W_ALU, W_WRD, W_F1,  8'h00},  // LOAD reg
        {4'b1100, 1'b1, 3'd3, W_ALU, W_IMW, W_F1,  8'h00},  // LOAD imm
        {4'b1101, 1'b1, 3'd3, W_ALU, W_IMW, W_F1,  8'h00},  // MOV imm
        {4'b1001, 1'b0, 3'd3, W_ALU, W_RD,  W_F1,  8'h00},  // COMP reg
        {4'b1001, 1'b1, 3'd3, W_ALU, W_RD,  W_F1,  8'h00},  // COMP imm
        {4'b1110, 1'b0, 3'd1, W_IDLE, 8'h00, 8'h00, 8'h00}, // HALT
        {4'b1011, 1'b1, 3'd1, W_IDLE, 8'h00, 8'h00, 8'h00}, // END
        {4'b1111, 1'b0, 3'd1, W_F1,  8'h00, 8'h00, 8'h00},  // NOP
        {4'b0101, 1'b0, 3'd3, W_ALU, W_WLO, W_F1,  8'h00},  // LSR reg
        {4'b0100, 1'b0, 3'd3, W_ARD, W_WLO, W_F1,  8'h00},  // OR reg
        {4'b1010, 1'b1, 3'd3, W_ALU, W_WLO, W_F1,  8'h00}   // NEG imm
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] opcode = 4'b1111;
    logic       imm_mode = 1'b0;
    logic       busy, ir_hi_load_n, ir_lo_load_n, alu_latch;
    logic       gpr_rd, gpr_wr, store_lo, store_hi;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    proc_ctrl_fsm i_proc_ctrl_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .opcode       (opcode),
        .imm_mode     (imm_mode),
        .busy         (busy),
        .ir_hi_load_n (ir_hi_load_n),
        .ir_lo_load_n (ir_lo_load_n),
        .alu_latch    (alu_latch),
        .gpr_rd       (gpr_rd),
        .gpr_wr       (gpr_wr),
        .store_lo     (store_lo),
        .store_hi     (store_hi)
    );

    function automatic logic [7:0] obs();
        return {busy, ir_hi_load_n, ir_lo_load_n, alu_latch,
                gpr_rd, gpr_wr, store_lo, store_hi};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic mode);
        if (op == 4'b0010)                    return "R7";
        if (op == 4'b1001)                    return "R9";
        if (op == 4'b1110 || op == 4'b1011)   return "R10";
        if (op == 4'b1111)                    return "R11";
        if (op == 4'b1100 || op == 4'b1101)   return mode ? "R8" : "R6";
        return mode ? "R5" : "R4";
    endfunction

    task automatic chk(input logic [7:0] exp, input string req);
        logic [7:0] got;
        got = obs();
        checks++;
        if ((!got[6] && !got[5]) || (got[1] && got[0]) || (got[2] && got[4]))
            overlaps++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s strobes got %b expected %b", req, got, exp);
        end
    endtask

    // Caller is at a falling edge with the machine idle
    task automatic run_vec(input logic [39:0] v, input bit hold_start);
        logic [3:0] op;
        logic       mode;
        int         n;
        op   = v[39:36];
        mode = v[35];
        n    = int'(v[34:32]);
        opcode   = op;
        imm_mode = mode;
        start    = 1'b1;
        @(negedge clk) chk(W_F1, "R3");
        start = hold_start;
        @(negedge clk) chk(W_F2, "R3");
        for (int k = 0; k < 4; k++) begin
            if (k < n) begin
                @(negedge clk);
                chk(v[31-8*k -: 8], hold_start ? "R12" : tag_of(op, mode));
            end
        end
        start = 1'b0;
        if (v[31-8*(n-1) -: 8] == W_F1) begin
            opcode = 4'b1110;
            @(negedge clk) chk(W_F2, "R3");
            @(negedge clk) chk(W_IDLE, "R10");
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk) chk(W_RST, "R1");
        rst = 1'b0;
        @(negedge clk) chk(W_IDLE, "R1");

        // R2: idle holds without start
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) chk(W_IDLE, "R2");
        end

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i], 1'b0);
        end

        // R12: start held high through execute has no effect
        run_vec(VEC[0], 1'b1);
        run_vec(VEC[2], 1'b1);

        // R1: reset in the middle of an instruction
        opcode   = 4'b0000;
        imm_mode = 1'b0;
        start    = 1'b1;
        @(negedge clk) chk(W_F1, "R3");
        start = 1'b0;
        @(negedge clk) chk(W_F2, "R3");
        rst = 1'b1;
        @(negedge clk) chk(W_RST, "R1");
        rst = 1'b0;
        @(negedge clk) chk(W_IDLE, "R1");

        // R13: no forbidden strobe overlap in any sampled cycle
        checks++;
        if (overlaps != 0) begin
            errors++;
            $display("FAIL R13 overlapping strobes seen %0d expected 0", overlaps);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule